// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block is a small memory subsystem on a 16-bit address bus carrying 8-bit data. It decodes every bus request into a select for one of three storage banks: a 4K×8 read-only firmware bank at the bottom of the map, and two 8K×8 read/write banks that together cover the following 16K. Every bank sits behind one shared read-return path. The path is steered by the select that was captured when the read was issued, so only the bank that was addressed can place data on it.

The read/write region begins at a 4K boundary, which does not line up with the 8K size of each bank. For that reason the decoder does not slice the top address bits. It subtracts the region base from the address, then takes the bank number and the internal location from the resulting offset. Requests above the read/write region are flagged as unmapped. Writes aimed at the firmware bank are dropped and reported as a write-error pulse. The read-only contents are produced by a fixed arithmetic pattern, so no file is needed to load them.

Top module: `mem_map_decoder`

## Requirements
- R1: While reset is held low at a clock edge, the following edge leaves `rd_valid`, `unmapped` and `wr_err` low and `rdata` at 0x00.
- R2: `bank_sel` is a combinational one-hot select that is all zero when `req` is low. With `req` high: bit 0 is set for 0x0000–0x0FFF, bit 1 for 0x1000–0x2FFF, bit 2 for 0x3000–0x4FFF, and no bit for 0x5000–0xFFFF.
- R3: A read request (`req` high, `we` low) sampled at a rising edge raises `rd_valid` for exactly the following cycle, and `rdata` holds the result during that cycle.
- R4: A read of address n in 0x0000–0x0FFF returns the low 8 bits of (n XOR (n >> 8)).
- R5: For an address a in 0x1000–0x4FFF, let the offset be o = a − 0x1000. A write stores `wdata` in bank o[13] at internal location o[12:0] on the request edge, and a later read of a returns that value.
- R6: A write to one read/write bank leaves unchanged the same internal location in the other read/write bank.
- R7: A write request in 0x0000–0x0FFF leaves the firmware contents unchanged and raises `wr_err` for exactly the following cycle. No other request raises `wr_err`.
- R8: A request in 0x5000–0xFFFF raises `unmapped` for the following cycle. If it is a read, `rdata` is 0xFF. If it is a write, no bank location changes.
- R9: In any cycle where `rd_valid` is low, `rdata` is 0x00. This covers the cycles after writes and the idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Bus request valid this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | System byte address |
| wdata | input | 8 | Write data |
| bank_sel | output | 3 | Decoded select: bit 0 firmware, bits 1–2 read/write banks |
| rdata | output | 8 | Shared read-return data, one cycle after the read |
| rd_valid | output | 1 | `rdata` carries a read result |
| unmapped | output | 1 | Previous request hit no bank |
| wr_err | output | 1 | Previous request was a write to the firmware bank |

## Verification
A write to one bank and a read of a different bank can occur on adjacent edges. In that case the bank that returns data must be the one captured with the read, never the one that has just been written. The main risk is a read that directly follows a write to the same internal location in the other bank. The bench provokes this in three ways: directed pairs at offsets 0x0234 and 0x0000 in both banks, a full preload of both banks with distinct values, and a long random stream that mixes regions and directions back to back. Every returned byte is compared against a flat 16K reference model indexed by the subtracted offset, which exposes aliasing or wrong-bank steering at once.

// File: rtl/mm_pkg.sv
// Package: shared constants and types for the banked memory map decoder.
// Assumes a byte-wide data bus; the fold shift defines the firmware pattern.
package mm_pkg;
    localparam int MM_ADDR_W    = 16;
    localparam int MM_DATA_W    = 8;
    localparam int MM_ROM_AW    = 12;
    localparam int MM_RAM_AW    = 13;
    localparam int MM_RAM_BANKS = 2;
    localparam int MM_FOLD      = 8;

    typedef enum logic [1:0] {
        RGN_ROM  = 2'd0,
        RGN_RAM  = 2'd1,
        RGN_NONE = 2'd2
    } region_e;
endpackage

// File: rtl/mm_decode.sv
// Module: mm_decode
// Purely combinational address decoder. The firmware bank occupies the
// lowest 2**ROM_AW bytes; the read/write region starts right above it and
// spans RAM_BANKS banks of 2**RAM_AW bytes. Because that base is not aligned
// to the bank size, the bank number and internal location come from the
// offset (addr - base), not from raw address bits.
module mm_decode #(
    parameter int ADDR_W    = mm_pkg::MM_ADDR_W,
    parameter int ROM_AW    = mm_pkg::MM_ROM_AW,
    parameter int RAM_AW    = mm_pkg::MM_RAM_AW,
    parameter int RAM_BANKS = mm_pkg::MM_RAM_BANKS
) (
    input  logic                  req,
    input  logic [ADDR_W-1:0]     addr,
    output mm_pkg::region_e       region,
    output logic [RAM_BANKS:0]    sel,
    output logic [ROM_AW-1:0]     rom_idx,
    output logic [RAM_AW-1:0]     ram_idx
);
    localparam int HI_W = ADDR_W - RAM_AW;
    localparam logic [ADDR_W-1:0] RAM_BASE = ADDR_W'(1) << ROM_AW;

    logic [ADDR_W-1:0] offset;
    logic [HI_W-1:0]   bank_hi;
    logic              in_rom;

    // Offset into the read/write region, split into bank number and location.
    always_comb begin
        offset  = addr - RAM_BASE;
        bank_hi = offset[ADDR_W-1:RAM_AW];
        ram_idx = offset[RAM_AW-1:0];
        rom_idx = addr[ROM_AW-1:0];
        in_rom  = (addr[ADDR_W-1:ROM_AW] == '0);
    end

    // Region classification and one-hot select generation.
    always_comb begin
        sel = '0;
        if (in_rom) begin
            region = mm_pkg::RGN_ROM;
        end else if (bank_hi < HI_W'(RAM_BANKS)) begin
            region = mm_pkg::RGN_RAM;
        end else begin
            region = mm_pkg::RGN_NONE;
        end
        if (req) begin
            if (region == mm_pkg::RGN_ROM) begin
                sel[0] = 1'b1;
            end
            for (int b = 0; b < RAM_BANKS; b++) begin
                if (region == mm_pkg::RGN_RAM && bank_hi == HI_W'(b)) begin
                    sel[b+1] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mm_rom.sv
// Module: mm_rom
// Read-only firmware bank with a registered read port. Contents are computed,
// not stored: word n is n XOR (n >> FOLD), truncated to DATA_W bits.
// Assumes en is asserted only for reads that select this bank.
module mm_rom #(
    parameter int ROM_AW = mm_pkg::MM_ROM_AW,
    parameter int DATA_W = mm_pkg::MM_DATA_W,
    parameter int FOLD   = mm_pkg::MM_FOLD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ROM_AW-1:0] idx,
    output logic [DATA_W-1:0] dout
);
    function automatic logic [DATA_W-1:0] word_at(input logic [ROM_AW-1:0] n);
        logic [DATA_W-1:0] w;
        w = '0;
        for (int i = 0; i < ROM_AW; i++) begin
            if (i < DATA_W) begin
                w[i % DATA_W] = w[i % DATA_W] ^ n[i];
            end
            if (i >= FOLD && (i - FOLD) < DATA_W) begin
                w[(i - FOLD) % DATA_W] = w[(i - FOLD) % DATA_W] ^ n[i];
            end
        end
        return w;
    endfunction

    // Registered read of the computed pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (en) begin
            dout <= word_at(idx);
        end
    end
endmodule

// File: rtl/mm_ram_bank.sv
// Module: mm_ram_bank
// One read/write bank of 2**AW words. Write is synchronous when en and we are
// high; read is registered with one cycle of latency when en is high and we
// is low. Assumes en is the decoded select for this bank only.
module mm_ram_bank #(
    parameter int AW     = mm_pkg::MM_RAM_AW,
    parameter int DATA_W = mm_pkg::MM_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [AW-1:0]     idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] dout
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage update, only for a selected write.
    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[idx] <= wdata;
        end
    end

    // Registered read port, loaded only for a selected read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (en && !we) begin
            dout <= mem[idx];
        end
    end
endmodule

// File: rtl/mem_map_decoder.sv
// Module: mem_map_decoder (top)
// Memory subsystem: decodes each request to the firmware bank or one of the
// read/write banks, steers the shared read-return path by the select captured
// with the read, flags unmapped requests and firmware writes one cycle later.
// Assumes one request per cycle and no wait states.
module mem_map_decoder #(
    parameter int ADDR_W    = mm_pkg::MM_ADDR_W,
    parameter int DATA_W    = mm_pkg::MM_DATA_W,
    parameter int ROM_AW    = mm_pkg::MM_ROM_AW,
    parameter int RAM_AW    = mm_pkg::MM_RAM_AW,
    parameter int RAM_BANKS = mm_pkg::MM_RAM_BANKS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [RAM_BANKS:0]   bank_sel,
    output logic [DATA_W-1:0]    rdata,
    output logic                 rd_valid,
    output logic                 unmapped,
    output logic                 wr_err
);
    localparam logic [ADDR_W-1:0] RAM_BASE = ADDR_W'(1) << ROM_AW;
    localparam logic [ADDR_W:0]   RAM_END  =
        (ADDR_W+1)'((1 << ROM_AW) + (RAM_BANKS << RAM_AW));

    mm_pkg::region_e                  region;
    logic [ROM_AW-1:0]                rom_idx;
    logic [RAM_AW-1:0]                ram_idx;
    logic [DATA_W-1:0]                rom_dout;
    logic [RAM_BANKS-1:0][DATA_W-1:0] ram_dout;
    logic [RAM_BANKS:0]               rd_sel_q;
    logic                             rd_valid_q;
    logic                             unmapped_q;
    logic                             wr_err_q;

    mm_decode #(
        .ADDR_W    (ADDR_W),
        .ROM_AW    (ROM_AW),
        .RAM_AW    (RAM_AW),
        .RAM_BANKS (RAM_BANKS)
    ) i_decode (
        .req     (req),
        .addr    (addr),
        .region  (region),
        .sel     (bank_sel),
        .rom_idx (rom_idx),
        .ram_idx (ram_idx)
    );

    mm_rom #(
        .ROM_AW (ROM_AW),
        .DATA_W (DATA_W)
    ) i_rom (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (bank_sel[0] & ~we),
        .idx   (rom_idx),
        .dout  (rom_dout)
    );

    for (genvar b = 0; b < RAM_BANKS; b++) begin : g_bank
        mm_ram_bank #(
            .AW     (RAM_AW),
            .DATA_W (DATA_W)
        ) i_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (bank_sel[b+1]),
            .we    (we),
            .idx   (ram_idx),
            .wdata (wdata),
            .dout  (ram_dout[b])
        );
    end

    // Capture the read select and the status of the current request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_sel_q   <= '0;
            rd_valid_q <= 1'b0;
            unmapped_q <= 1'b0;
            wr_err_q   <= 1'b0;
        end else begin
            rd_sel_q   <= we ? '0 : bank_sel;
            rd_valid_q <= req & ~we;
            unmapped_q <= req & (region == mm_pkg::RGN_NONE);
            wr_err_q   <= req & we & (region == mm_pkg::RGN_ROM);
        end
    end

    // Shared return path: only the bank captured with the read contributes.
    always_comb begin
        rdata = '0;
        if (rd_valid_q && unmapped_q) begin
            rdata = '1;
        end
        if (rd_sel_q[0]) begin
            rdata = rdata | rom_dout;
        end
        for (int b = 0; b < RAM_BANKS; b++) begin
            if (rd_sel_q[b+1]) begin
                rdata = rdata | ram_dout[b];
            end
        end
    end

    assign rd_valid = rd_valid_q;
    assign unmapped = unmapped_q;
    assign wr_err   = wr_err_q;

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_sel)); // R2
    AST_MAPPED_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (req && {1'b0, addr} < RAM_END) |-> $countones(bank_sel) == 1); // R2
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we) |=> rd_valid); // R3
    AST_ROM_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && addr < RAM_BASE) |=> wr_err); // R7
    AST_WR_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(req && we)); // R7
    AST_UNMAPPED_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && unmapped) |-> rdata == '1); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rdata == '0); // R9
endmodule

// File: tb/test_mem_map_decoder.sv
`timescale 1ns/1ps
module test_mem_map_decoder;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req;
    logic        we;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [2:0]  bank_sel;
    logic [7:0]  rdata;
    logic        rd_valid;
    logic        unmapped;
    logic        wr_err;

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    logic [7:0] mdl [16384];

    always #4 clk = ~clk;

    mem_map_decoder i_mem_map_decoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .we       (we),
        .addr     (addr),
        .wdata    (wdata),
        .bank_sel (bank_sel),
        .rdata    (rdata),
        .rd_valid (rd_valid),
        .unmapped (unmapped),
        .wr_err   (wr_err)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rom_exp(input logic [15:0] a);
        logic [15:0] t;
        t = a ^ (a >> 8);
        return t[7:0];
    endfunction

    function automatic logic [2:0] sel_exp(input logic [15:0] a);
        if (a < 16'h1000) return 3'b001;
        if (a < 16'h3000) return 3'b010;
        if (a < 16'h5000) return 3'b100;
        return 3'b000;
    endfunction

    // One request cycle with full checking of decode and registered outputs.
    task automatic op(input logic w, input logic [15:0] a, input logic [7:0] d);
        logic [7:0] er;
        string      rq;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        #1;
        chk(bank_sel == sel_exp(a), "R2", "bank_sel", 16'(bank_sel), 16'(sel_exp(a)));
        if (w) begin
            er = 8'h00; rq = "R9";
            if (a >= 16'h1000 && a < 16'h5000) mdl[a - 16'h1000] = d;
        end else if (a < 16'h1000) begin
            er = rom_exp(a); rq = "R4";
        end else if (a < 16'h5000) begin
            er = mdl[a - 16'h1000]; rq = "R5";
        end else begin
            er = 8'hFF; rq = "R8";
        end
        @(posedge clk);
        #2;
        chk(rd_valid == !w, "R3", "rd_valid", 16'(rd_valid), 16'(!w));
        chk(rdata === er, rq, "rdata", 16'(rdata), 16'(er));
        chk(unmapped == (a >= 16'h5000), "R8", "unmapped", 16'(unmapped), 16'(a >= 16'h5000));
        chk(wr_err == (w && a < 16'h1000), "R7", "wr_err", 16'(wr_err), 16'(w && a < 16'h1000));
        req = 1'b0; we = 1'b0;
    endtask

    // One idle cycle: nothing selected, all outputs quiet afterwards.
    task automatic idle();
        @(negedge clk);
        req = 1'b0; we = 1'b0; addr = 16'h2222;
        #1;
        chk(bank_sel == 3'b000, "R2", "idle bank_sel", 16'(bank_sel), 16'h0);
        @(posedge clk);
        #2;
        chk(rdata == 8'h00, "R9", "idle rdata", 16'(rdata), 16'h0);
        chk(rd_valid == 1'b0, "R3", "idle rd_valid", 16'(rd_valid), 16'h0);
        chk(wr_err == 1'b0, "R7", "idle wr_err", 16'(wr_err), 16'h0);
        chk(unmapped == 1'b0, "R8", "idle unmapped", 16'(unmapped), 16'h0);
    endtask

    initial begin
        logic [31:0] r;
        logic [15:0] a;
        rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        r = $urandom(32'h5EED_0042);
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        chk(rd_valid == 1'b0, "R1", "rd_valid", 16'(rd_valid), 16'h0);
        chk(unmapped == 1'b0, "R1", "unmapped", 16'(unmapped), 16'h0);
        chk(wr_err == 1'b0, "R1", "wr_err", 16'(wr_err), 16'h0);
        chk(rdata == 8'h00, "R1", "rdata", 16'(rdata), 16'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Preload both read/write banks with distinct values (R5).
        for (int i = 0; i < 16384; i++) begin
            op(1'b1, 16'h1000 + 16'(i), 8'(i * 7 + i / 256 + 3));
        end

        // Region boundaries (R4, R5, R8).
        op(1'b0, 16'h0000, 8'h00);
        op(1'b0, 16'h0FFF, 8'h00);
        op(1'b0, 16'h1000, 8'h00);
        op(1'b0, 16'h2FFF, 8'h00);
        op(1'b0, 16'h3000, 8'h00);
        op(1'b0, 16'h4FFF, 8'h00);
        op(1'b0, 16'h5000, 8'h00);
        op(1'b0, 16'hFFFF, 8'h00);

        // R6: same internal location in both banks, write then read back-to-back.
        op(1'b1, 16'h1234, 8'hA5);
        op(1'b1, 16'h3234, 8'h5A);
        op(1'b0, 16'h1234, 8'h00);
        op(1'b0, 16'h3234, 8'h00);
        op(1'b1, 16'h3000, 8'hC3);
        op(1'b0, 16'h1000, 8'h00);
        op(1'b0, 16'h3000, 8'h00);

        // R7: firmware writes ignored, single-cycle error pulse.
        op(1'b1, 16'h0010, 8'h00);
        idle();
        op(1'b0, 16'h0010, 8'h00);
        op(1'b1, 16'h0FFF, 8'h00);
        op(1'b0, 16'h0FFF, 8'h00);

        // R8: unmapped writes whose low bits alias bank locations change nothing.
        op(1'b1, 16'h5000, 8'h77);
        op(1'b1, 16'h7000, 8'h88);
        op(1'b0, 16'h1000, 8'h00);
        op(1'b0, 16'h3000, 8'h00);
        idle();

        // Random mix across all regions.
        for (int k = 0; k < 3000; k++) begin
            r = $urandom;
            case (r[1:0])
                2'd0: a = {4'h0, 12'(r[31:20])};
                2'd1: a = 16'h1000 + 16'(r[31:19] & 13'h1FFF);
                2'd2: a = 16'h3000 + 16'(r[31:19] & 13'h1FFF);
                default: a = 16'h5000 + 16'(r[31:16] % 16'hB000);
            endcase
            op(r[2], a, r[15:8]);
            if (r[5:3] == 3'd0) idle();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule